// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which reset sources have fired. Four one-cycle event inputs (power-on, external pin, brown-out and watchdog) each set a sticky flag. Software reads the flags through a small register port after startup to learn why the chip restarted, then clears them by writing zeros. The flags have no reset input. The power-on event acts as their reset: it clears the three other flags and sets its own.

The power-on flag follows a rule of its own. No reset event ever clears it. Only a software write of zero to its bit does. So if software clears the flags early, a later look at the register shows whether power was lost in between. The read port is combinational: read data follows the address in the same cycle. A flag change shows in read data right after the clock edge that captures it. Before the first power-on event the flag contents are undefined.

Top module: `rcs_status_reg`

## Requirements
- R1: Flags sit in bits 3..0 of the register: bit 3 watchdog, bit 2 brown-out, bit 1 external, bit 0 power-on.
- R2: Read data bits DATA_W-1..4 are always zero.
- R3: A pulse on an event input sets its flag. The flag reads as 1 from the next cycle.
- R4: A write at REG_ADDR with a 0 in a flag's bit position clears that flag on the next cycle.
- R5: A write at REG_ADDR with a 1 in a flag's bit position leaves that flag unchanged.
- R6: A power-on event clears the watchdog, brown-out and external flags.
- R7: No event input ever clears the power-on flag. Only a write of 0 to bit 0 at REG_ADDR clears it.
- R8: If a flag's event and a write clearing that flag fall in the same cycle, the flag ends up set.
- R9: Several events in one cycle each set their own flag. A power-on event in that cycle clears only those other flags whose events are absent, and the power-on flag ends up set.
- R10: A write to any address other than REG_ADDR changes no flag. A read at any other address returns zero.
- R11: Read data is combinational from the address and the flags, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ev_por | input | 1 | Power-on reset event, one-cycle pulse |
| ev_ext | input | 1 | External pin reset event, one-cycle pulse |
| ev_bor | input | 1 | Brown-out reset event, one-cycle pulse |
| ev_wdt | input | 1 | Watchdog reset event, one-cycle pulse |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data; a 0 bit clears the flag at that position |
| bus_rdata | output | DATA_W | Read data; flags in bits 3..0, upper bits zero |

## Verification
Two things can land on the same flag in one cycle: a reset event setting it, and a software write clearing it (directly, or indirectly through the power-on clear of the other flags). The bench first loads every possible starting flag pattern. For each one it applies every combination of the four events together with every write-data pattern, with no write, a write at the register address, and a write at another address. For each flag bit it computes the expected value from the priority set > power-on clear > write clear > hold, and it names the rule that decided the bit when it reports a mismatch.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // Bit positions of the flags; software decodes these positions.
   typedef enum int unsigned {
      FLG_POR = 0,
      FLG_EXT = 1,
      FLG_BOR = 2,
      FLG_WDT = 3
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 4;

endpackage

// File: rtl/rcs_addr_dec.sv
module rcs_addr_dec #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned REG_ADDR = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              hit,
   output logic              wr_hit
);

   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

   always_comb begin
      hit    = (addr == MATCH);
      wr_hit = hit & wr;
   end

endmodule

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell #(
   parameter bit CLR_ON_POR = 1'b1
) (
   input  logic clk,
   input  logic set_evt,
   input  logic por_evt,
   input  logic wr_clr,
   output logic q
);

   logic nxt;
   logic por_clr;

   generate
      if (CLR_ON_POR) begin : g_por_clears
         assign por_clr = por_evt;
      end else begin : g_por_keeps
         logic unused_por;
         assign unused_por = por_evt;
         assign por_clr    = 1'b0;
      end
   endgenerate

   // Priority: own event sets, then power-on clear, then software clear, then hold.
   always_comb begin
      if (set_evt)
         nxt = 1'b1;
      else if (por_clr)
         nxt = 1'b0;
      else if (wr_clr)
         nxt = 1'b0;
      else
         nxt = q;
   end

   always_ff @(posedge clk) begin
      q <= nxt;
   end

endmodule

// File: rtl/rcs_rd_mux.sv
module rcs_rd_mux #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NF     = 4
) (
   input  logic              hit,
   input  logic [NF-1:0]     flags,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - NF;

   logic [DATA_W-1:0] word;

   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {{PAD_W{1'b0}}, flags};
      end else begin : g_nopad
         assign word = flags;
      end
   endgenerate

   assign rdata = hit ? word : '0;

endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
   import rcs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned REG_ADDR = 4
) (
   input  logic              clk,
   input  logic              ev_por,
   input  logic              ev_ext,
   input  logic              ev_bor,
   input  logic              ev_wdt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int unsigned NF = NUM_FLAGS;

   generate
      if (DATA_W < NF) begin : g_bad_width
         $error("rcs_status_reg: DATA_W must hold all flags");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("rcs_status_reg: ADDR_W out of range");
      end
      if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("rcs_status_reg: REG_ADDR does not fit ADDR_W");
      end
   endgenerate

   logic          hit;
   logic          wr_hit;
   logic [NF-1:0] ev_vec;
   logic [NF-1:0] wr_clr;
   logic [NF-1:0] flags_q;

   always_comb begin
      ev_vec               = '0;
      ev_vec[int'(FLG_POR)] = ev_por;
      ev_vec[int'(FLG_EXT)] = ev_ext;
      ev_vec[int'(FLG_BOR)] = ev_bor;
      ev_vec[int'(FLG_WDT)] = ev_wdt;
   end

   rcs_addr_dec #(
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR)
   ) u_dec (
      .addr  (bus_addr),
      .wr    (bus_wr),
      .hit   (hit),
      .wr_hit(wr_hit)
   );

   assign wr_clr = {NF{wr_hit}} & ~bus_wdata[NF-1:0];

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         rcs_flag_cell #(
            .CLR_ON_POR(i != int'(FLG_POR))
         ) u_cell (
            .clk    (clk),
            .set_evt(ev_vec[i]),
            .por_evt(ev_por),
            .wr_clr (wr_clr[i]),
            .q      (flags_q[i])
         );
      end
      if (DATA_W > NF) begin : g_unused_wdata
         logic unused_wdata;
         assign unused_wdata = ^bus_wdata[DATA_W-1:NF];
      end
   endgenerate

   rcs_rd_mux #(
      .DATA_W(DATA_W),
      .NF    (NF)
   ) u_rd (
      .hit  (hit),
      .flags(flags_q),
      .rdata(bus_rdata)
   );

endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned REG_ADDR = 4
) (
   input logic              clk,
   input logic              ev_por,
   input logic              ev_ext,
   input logic              ev_bor,
   input logic              ev_wdt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [3:0]        flags
);

   // Flags are defined only once a power-on event has been captured.
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (ev_por) armed <= 1'b1;
   end

   logic at_reg;
   logic any_ev;
   assign at_reg = (bus_addr == ADDR_W'(REG_ADDR));
   assign any_ev = ev_por | ev_ext | ev_bor | ev_wdt;

   // R3 / R8 / R9: an event always leaves its flag set.
   a_r3_wdt_set: assert property (@(posedge clk) disable iff (!armed)
      ev_wdt |=> flags[3]);
   a_r3_bor_set: assert property (@(posedge clk) disable iff (!armed)
      ev_bor |=> flags[2]);
   a_r3_ext_set: assert property (@(posedge clk) disable iff (!armed)
      ev_ext |=> flags[1]);
   a_r9_por_set: assert property (@(posedge clk) disable iff (!armed)
      ev_por |=> flags[0]);

   // R6: power-on clears others whose events are absent.
   a_r6_por_clr_ext: assert property (@(posedge clk) disable iff (!armed)
      (ev_por && !ev_ext) |=> !flags[1]);
   a_r6_por_clr_wdt: assert property (@(posedge clk) disable iff (!armed)
      (ev_por && !ev_wdt) |=> !flags[3]);

   // R7: power-on flag survives everything but a zero write at the register.
   a_r7_por_sticky: assert property (@(posedge clk) disable iff (!armed)
      (flags[0] && !(bus_wr && at_reg && !bus_wdata[0])) |=> flags[0]);

   // R10: off-address writes with no events leave the flags alone.
   a_r10_miss_write: assert property (@(posedge clk) disable iff (!armed)
      (bus_wr && !at_reg && !any_ev) |=> $stable(flags));

   // R2: upper read bits stay zero.
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!armed)
      bus_rdata[DATA_W-1:4] == '0);

   // R10: reads elsewhere return zero.
   a_r10_miss_read: assert property (@(posedge clk) disable iff (!armed)
      !at_reg |-> bus_rdata == '0);

endmodule

bind rcs_status_reg rcs_status_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .REG_ADDR(REG_ADDR)
) u_chk (
   .clk      (clk),
   .ev_por   (ev_por),
   .ev_ext   (ev_ext),
   .ev_bor   (ev_bor),
   .ev_wdt   (ev_wdt),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .flags    (flags_q)
);

// File: tb/sim_rcs_status_reg.sv
module sim_rcs_status_reg;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;
   localparam int DATA_W     = 8;
   localparam int REG_ADDR   = 4;
   localparam logic [ADDR_W-1:0] HIT_A  = ADDR_W'(REG_ADDR);
   localparam logic [ADDR_W-1:0] MISS_A = ADDR_W'(REG_ADDR) ^ 4'h1;

   logic              clk = 1'b0;
   logic              ev_por = 0, ev_ext = 0, ev_bor = 0, ev_wdt = 0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcs_status_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u0 (
      .clk(clk), .ev_por(ev_por), .ev_ext(ev_ext), .ev_bor(ev_bor), .ev_wdt(ev_wdt),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // ev: {wdt,bor,ext,por}; one cycle with events and an optional write.
   task automatic cycle(input logic [3:0] ev, input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd);
      @(negedge clk);
      {ev_wdt, ev_bor, ev_ext, ev_por} = ev;
      bus_wr    = wr;
      bus_addr  = a;
      bus_wdata = wd;
      @(posedge clk);
      #1;
      {ev_wdt, ev_bor, ev_ext, ev_por} = 4'b0;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // Load flag pattern p through the normal interface.
   task automatic load(input logic [3:0] p);
      cycle(4'b0001, 1'b0, HIT_A, '0);
      if (p[3:1] != 3'b0) cycle({p[3:1], 1'b0}, 1'b0, HIT_A, '0);
      if (!p[0]) cycle(4'b0, 1'b1, HIT_A, 8'hFE);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] d;

      // Power-on state after first power-on event: R7 R6 R1
      cycle(4'b0001, 1'b0, HIT_A, '0);
      rd(HIT_A, d); chk("R7 reset state por flag", d, 8'h01);

      // R1: positions of each flag
      cycle(4'b1000, 1'b0, HIT_A, '0);
      rd(HIT_A, d); chk("R1 watchdog at bit 3", d, 8'h09);
      cycle(4'b0001, 1'b0, HIT_A, '0);
      cycle(4'b0100, 1'b0, HIT_A, '0);
      rd(HIT_A, d); chk("R1 brown-out at bit 2", d, 8'h05);
      cycle(4'b0001, 1'b0, HIT_A, '0);
      cycle(4'b0010, 1'b0, HIT_A, '0);
      rd(HIT_A, d); chk("R1 external at bit 1", d, 8'h03);

      // R11: read follows address without a clock edge
      rd(MISS_A, d); chk("R11 read elsewhere same cycle", d, 8'h00);
      rd(HIT_A, d);  chk("R11 read back same cycle", d, 8'h03);

      // R7: events other than power-on never clear bit 0
      cycle(4'b1110, 1'b0, HIT_A, '0);
      rd(HIT_A, d); chk("R7 por flag kept by other events", d, 8'h0F);

      // R4: zero write clears only por
      cycle(4'b0, 1'b1, HIT_A, 8'hFE);
      rd(HIT_A, d); chk("R4 clear bit 0 only", d, 8'h0E);

      // Exhaustive sweep
      for (int p = 0; p < 16; p++) begin
         for (int ev = 0; ev < 16; ev++) begin
            for (int wd = 0; wd < 16; wd++) begin
               for (int mode = 0; mode < 3; mode++) begin
                  logic       wr;
                  logic       miss;
                  logic [3:0] exp;
                  wr   = (mode != 0);
                  miss = (mode == 2);
                  load(4'(p));
                  rd(HIT_A, d);
                  chk("R3 load pattern", d, {4'b0, 4'(p)});
                  cycle(4'(ev), wr, miss ? MISS_A : HIT_A, {4'hF, 4'(wd)} ^ 8'hF0);
                  for (int i = 0; i < 4; i++) begin
                     string tag;
                     if (ev[i]) begin
                        exp[i] = 1'b1;
                        if (wr && !miss && !wd[i]) tag = "R8";
                        else if (ev[0] && i != 0) tag = "R9";
                        else tag = "R3";
                     end else if (ev[0] && i != 0) begin
                        exp[i] = 1'b0; tag = "R6";
                     end else if (wr && !miss && !wd[i]) begin
                        exp[i] = 1'b0; tag = "R4";
                     end else begin
                        exp[i] = p[i];
                        if (wr && miss) tag = "R10";
                        else if (wr) tag = "R5";
                        else tag = (i == 0) ? "R7" : "R3";
                     end
                     rd(HIT_A, d);
                     chk($sformatf("%s flag bit %0d p=%h ev=%h wd=%h mode=%0d", tag, i, p, ev, wd, mode),
                         {7'b0, d[i]}, {7'b0, exp[i]});
                  end
                  chk("R2 upper bits zero", {4'b0, d[7:4]}, 8'h00);
                  rd(MISS_A, d);
                  chk("R10 off-address read zero", d, 8'h00);
               end
            end
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule